// File: doc/BRIEF.md
# DMA Channel Register and Command Unit

This block is the control face of a multi-channel, descriptor-driven DMA engine. A processor reaches it over a 32-bit word bus. Each channel has its own 8 KiB address window. The block keeps each channel's pointer, configuration and interrupt registers, and it tracks a small one-hot channel state. It assembles a status word for readback and drives one level interrupt line per channel.

Writes to the stream-command register and to the command register are turned into single-cycle strobes for the neighbouring transfer engine. There are three strobes: fetch the data descriptor, fetch the context descriptor, and start. The engine reports back four things: busy, end-of-list reached, the end-of-list bit of its current data descriptor, and raw interrupt events. The engine reads the descriptor pointers it needs straight from output ports.

Top module: `dma_chan_regs`

## Requirements
- R1: Every bus request gets `bus_ack` exactly one cycle later. `bus_rdata` is registered and is valid in the same cycle as that acknowledge.
- R2: The address holds the channel index in bits above 12 and the word register index in bits 7:2. A request with `bus_be` other than 4'hF, or with a channel index of `NUM_CH` or more, raises `bus_err` together with `bus_ack` and changes no register.
- R3: After reset, status reads 0x101, configuration reads 0, and `irq` is low. Status is laid out as follows: state in bits 2:0 (one-hot: reset state = 1, stopped = 2, running = 4), the engine's end-of-list flag in bit 5, and a constant 1 in bit 8.
- R4: A configuration write (offset 0x84) with bit 0 clear puts the channel in the reset state. A write with bit 0 set and bit 1 set puts it in the stopped state. A write with bit 0 set and bit 1 clear leaves the state unchanged.
- R5: A stream-command write (offset 0x9C) that has any of bits 8 or 6 set pulses `eng_load_d`. If bit 5 is also set, it pulses `eng_start` as well and the channel becomes running. Bits above 9 are ignored.
- R6: A stream-command write with bit 9 set pulses `eng_load_c`. Bit 5 on its own produces no strobe.
- R7: A command write (offset 0x80) with bit 0 set pulses both `eng_load_d` and `eng_start`. This happens only when configuration bit 0 is 1, configuration bit 1 is 0, the state is running, and `eng_desc_eol` is high. Otherwise no strobe is produced.
- R8: Strobes are one cycle wide and appear in the cycle after the write is accepted. While the channel's `eng_busy` is high, a command or stream-command write produces no strobe and no state change.
- R9: Raw interrupt bits (offset 0x94, `IRQ_W` bits) are set by `eng_irq_set`. Writing the acknowledge register (offset 0x90) clears the raw bits that are 1 in the written value. The acknowledge register itself always reads 0.
- R10: The masked register (offset 0x98) reads raw AND mask, where the mask is at offset 0x8C. `irq` is high in exactly the cycles where this value is nonzero, and it follows a mask, acknowledge or set event from the next cycle on.
- R11: Pointer registers (0x00, 0x58, 0x5C, 0x60, 0x7C) read back what was written, separately for each channel. Offset 0x58 drives `desc_ptr` and offset 0x7C drives `ctx_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_req | input | 1 | bus request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | byte address |
| bus_be | input | 4 | byte enables, 4'hF for a word access |
| bus_wdata | input | 32 | write data |
| bus_ack | output | 1 | access done |
| bus_err | output | 1 | access rejected |
| bus_rdata | output | 32 | read data |
| eng_busy | input | NUM_CH | engine busy per channel |
| eng_eol | input | NUM_CH | engine reached end of list |
| eng_desc_eol | input | NUM_CH | current data descriptor has end-of-list set |
| eng_irq_set | input | NUM_CH*IRQ_W | raw interrupt set pulses |
| eng_load_d | output | NUM_CH | data descriptor fetch strobe |
| eng_load_c | output | NUM_CH | context descriptor fetch strobe |
| eng_start | output | NUM_CH | start strobe |
| desc_ptr | output | NUM_CH*32 | saved data descriptor pointer per channel |
| ctx_ptr | output | NUM_CH*32 | context descriptor pointer per channel |
| irq | output | NUM_CH | level interrupt per channel |

## Verification
The bench builds the block with `NUM_CH` = 3 and `IRQ_W` = 4. Three channels are not a power of two, so the two-bit channel field has an unused code, 3, and that makes the out-of-range error path reachable. A third channel also lets the bench show that a write to one channel leaves another untouched. The 4-bit raw field is wide enough to set, mask and acknowledge separate bits independently.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [2:0] {
    ST_RST  = 3'b001,
    ST_STOP = 3'b010,
    ST_RUN  = 3'b100
  } ch_state_e;

  localparam logic [5:0] IX_DATA  = 6'h00;
  localparam logic [5:0] IX_SVD   = 6'h16;
  localparam logic [5:0] IX_SVB   = 6'h17;
  localparam logic [5:0] IX_GRP   = 6'h18;
  localparam logic [5:0] IX_GDN   = 6'h1F;
  localparam logic [5:0] IX_CMD   = 6'h20;
  localparam logic [5:0] IX_CFG   = 6'h21;
  localparam logic [5:0] IX_STAT  = 6'h22;
  localparam logic [5:0] IX_MASK  = 6'h23;
  localparam logic [5:0] IX_ACK   = 6'h24;
  localparam logic [5:0] IX_RAW   = 6'h25;
  localparam logic [5:0] IX_MSKD  = 6'h26;
  localparam logic [5:0] IX_STRM  = 6'h27;

  localparam logic [9:0] STRM_LD_D = 10'h140;
  localparam int         STRM_GO   = 5;
  localparam int         STRM_LD_C = 9;
  localparam int         WIN_LSB   = 13;
endpackage

// File: rtl/dmac_decode.sv
module dmac_decode #(
  parameter int NUM_CH = 3,
  parameter int CH_W   = 2,
  parameter int ADDR_W = 15
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  output logic [CH_W-1:0]   ch,
  output logic [5:0]        idx,
  output logic              bad,
  output logic [NUM_CH-1:0] wr_sel
);
  logic unused_bits;
  assign unused_bits = ^{addr[12:8], addr[1:0]};
  assign ch  = addr[ADDR_W-1:dmac_pkg::WIN_LSB];
  assign idx = addr[7:2];
  assign bad = (be != 4'hF) || (32'(ch) >= NUM_CH);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    assign wr_sel[g] = req && we && !bad && (32'(ch) == g);
  end
endmodule

// File: rtl/dmac_irq.sv
module dmac_irq #(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_mask,
  input  logic             wr_ack,
  input  logic [31:0]      wdata,
  input  logic [IRQ_W-1:0] set,
  output logic [IRQ_W-1:0] raw,
  output logic [IRQ_W-1:0] mask,
  output logic             irq
);
  logic [IRQ_W-1:0] raw_nx, mask_nx, clr;

  always_comb begin
    clr     = wr_ack ? wdata[IRQ_W-1:0] : '0;
    raw_nx  = (raw & ~clr) | set;
    mask_nx = wr_mask ? wdata[IRQ_W-1:0] : mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw  <= '0;
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      raw  <= raw_nx;
      mask <= mask_nx;
      irq  <= |(raw_nx & mask_nx);
    end
  end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [5:0]       idx,
  input  logic [31:0]      wdata,
  input  logic             eng_busy,
  input  logic             eng_eol,
  input  logic             desc_eol,
  input  logic [IRQ_W-1:0] irq_set,
  output logic [31:0]      rval,
  output logic             load_d,
  output logic             load_c,
  output logic             start,
  output logic             irq,
  output logic [31:0]      desc_ptr,
  output logic [31:0]      ctx_ptr
);
  ch_state_e        state;
  logic [31:0]      r_data, r_svd, r_svb, r_grp, r_gdn, r_cmd, r_cfg, r_strm;
  logic [IRQ_W-1:0] raw, mask;
  logic             wr_cmd, wr_cfg, wr_strm, wr_mask, wr_ack;
  logic             s_ld_d, s_ld_c, s_go, cont_ok, go_d, go_c, go_s;

  always_comb begin
    wr_cmd  = wr && idx == IX_CMD;
    wr_cfg  = wr && idx == IX_CFG;
    wr_strm = wr && idx == IX_STRM;
    wr_mask = wr && idx == IX_MASK;
    wr_ack  = wr && idx == IX_ACK;
    s_ld_d  = |(wdata[9:0] & STRM_LD_D);
    s_go    = s_ld_d && wdata[STRM_GO];
    s_ld_c  = wdata[STRM_LD_C];
    cont_ok = wr_cmd && wdata[0] && r_cfg[0] && !r_cfg[1]
              && state == ST_RUN && desc_eol;
    go_d    = !eng_busy && ((wr_strm && s_ld_d) || cont_ok);
    go_s    = !eng_busy && ((wr_strm && s_go) || cont_ok);
    go_c    = !eng_busy && wr_strm && s_ld_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_RST;
      r_data <= '0; r_svd <= '0; r_svb <= '0; r_grp <= '0;
      r_gdn  <= '0; r_cmd <= '0; r_cfg <= '0; r_strm <= '0;
      load_d <= 1'b0; load_c <= 1'b0; start <= 1'b0;
    end else begin
      load_d <= go_d;
      load_c <= go_c;
      start  <= go_s;
      if (go_s) state <= ST_RUN;
      if (wr_cfg) begin
        r_cfg <= wdata;
        if (!wdata[0])     state <= ST_RST;
        else if (wdata[1]) state <= ST_STOP;
      end
      if (wr) begin
        case (idx)
          IX_DATA: r_data <= wdata;
          IX_SVD:  r_svd  <= wdata;
          IX_SVB:  r_svb  <= wdata;
          IX_GRP:  r_grp  <= wdata;
          IX_GDN:  r_gdn  <= wdata;
          IX_CMD:  r_cmd  <= wdata;
          IX_STRM: r_strm <= wdata;
          default: ;
        endcase
      end
    end
  end

  dmac_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk(clk), .rst(rst), .wr_mask(wr_mask), .wr_ack(wr_ack),
    .wdata(wdata), .set(irq_set), .raw(raw), .mask(mask), .irq(irq)
  );

  always_comb begin
    case (idx)
      IX_DATA: rval = r_data;
      IX_SVD:  rval = r_svd;
      IX_SVB:  rval = r_svb;
      IX_GRP:  rval = r_grp;
      IX_GDN:  rval = r_gdn;
      IX_CMD:  rval = r_cmd;
      IX_CFG:  rval = r_cfg;
      IX_STAT: rval = {23'd0, 1'b1, 2'b00, eng_eol, 2'b00, state};
      IX_MASK: rval = 32'(mask);
      IX_RAW:  rval = 32'(raw);
      IX_MSKD: rval = 32'(raw & mask);
      IX_STRM: rval = r_strm;
      default: rval = '0;
    endcase
  end

  assign desc_ptr = r_svd;
  assign ctx_ptr  = r_gdn;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NUM_CH = 3,
  parameter int IRQ_W  = 4,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + dmac_pkg::WIN_LSB
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_req,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [3:0]              bus_be,
  input  logic [31:0]             bus_wdata,
  output logic                    bus_ack,
  output logic                    bus_err,
  output logic [31:0]             bus_rdata,
  input  logic [NUM_CH-1:0]       eng_busy,
  input  logic [NUM_CH-1:0]       eng_eol,
  input  logic [NUM_CH-1:0]       eng_desc_eol,
  input  logic [NUM_CH*IRQ_W-1:0] eng_irq_set,
  output logic [NUM_CH-1:0]       eng_load_d,
  output logic [NUM_CH-1:0]       eng_load_c,
  output logic [NUM_CH-1:0]       eng_start,
  output logic [NUM_CH*32-1:0]    desc_ptr,
  output logic [NUM_CH*32-1:0]    ctx_ptr,
  output logic [NUM_CH-1:0]       irq
);
  logic [CH_W-1:0]   ch;
  logic [5:0]        idx;
  logic              bad;
  logic [NUM_CH-1:0] wr_sel;
  logic [31:0]       rval [NUM_CH];
  logic [31:0]       rsel;

  dmac_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
    .req(bus_req), .we(bus_we), .addr(bus_addr), .be(bus_be),
    .ch(ch), .idx(idx), .bad(bad), .wr_sel(wr_sel)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dmac_chan #(.IRQ_W(IRQ_W)) u_ch (
      .clk(clk), .rst(rst), .wr(wr_sel[g]), .idx(idx), .wdata(bus_wdata),
      .eng_busy(eng_busy[g]), .eng_eol(eng_eol[g]), .desc_eol(eng_desc_eol[g]),
      .irq_set(eng_irq_set[g*IRQ_W +: IRQ_W]), .rval(rval[g]),
      .load_d(eng_load_d[g]), .load_c(eng_load_c[g]), .start(eng_start[g]),
      .irq(irq[g]), .desc_ptr(desc_ptr[g*32 +: 32]), .ctx_ptr(ctx_ptr[g*32 +: 32])
    );
  end

  always_comb begin
    rsel = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (32'(ch) == i) rsel = rval[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_req;
      bus_err   <= bus_req && bad;
      bus_rdata <= (bus_req && !bus_we && !bad) ? rsel : '0;
    end
  end
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_err,
  input logic [NUM_CH-1:0] eng_busy,
  input logic [NUM_CH-1:0] eng_load_d,
  input logic [NUM_CH-1:0] eng_load_c,
  input logic [NUM_CH-1:0] eng_start
);
  a_r1_ack_follows_req: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> bus_ack);
  a_r1_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
    !bus_req |=> !bus_ack);
  a_r2_err_with_ack: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> bus_ack);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_p
    a_r5_start_with_load: assert property (@(posedge clk) disable iff (rst)
      eng_start[g] |-> eng_load_d[g]);
    a_r8_busy_blocks_load_d: assert property (@(posedge clk) disable iff (rst)
      eng_load_d[g] |-> !$past(eng_busy[g]));
    a_r8_busy_blocks_load_c: assert property (@(posedge clk) disable iff (rst)
      eng_load_c[g] |-> !$past(eng_busy[g]));
    a_r8_strobe_needs_req: assert property (@(posedge clk) disable iff (rst)
      (eng_load_d[g] || eng_load_c[g]) |-> $past(bus_req));
  end
endmodule

bind dma_chan_regs dmac_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_ack(bus_ack), .bus_err(bus_err),
  .eng_busy(eng_busy), .eng_load_d(eng_load_d), .eng_load_c(eng_load_c),
  .eng_start(eng_start)
);

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;
  localparam int NUM_CH = 3;
  localparam int IRQ_W  = 4;
  localparam int CH_W   = 2;
  localparam int ADDR_W = CH_W + 13;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_req = 0, bus_we = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [3:0] bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic bus_ack, bus_err;
  logic [31:0] bus_rdata;
  logic [NUM_CH-1:0] eng_busy = '0, eng_eol = '0, eng_desc_eol = '0;
  logic [NUM_CH*IRQ_W-1:0] eng_irq_set = '0;
  logic [NUM_CH-1:0] eng_load_d, eng_load_c, eng_start, irq;
  logic [NUM_CH*32-1:0] desc_ptr, ctx_ptr;

  int checks = 0, errors = 0;
  logic c_err, c_ld_d, c_ld_c, c_st;
  logic [31:0] c_rd;

  always #2 clk = ~clk;

  dma_chan_regs #(.NUM_CH(NUM_CH), .IRQ_W(IRQ_W)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input int ch, input logic [7:0] off, input logic we,
                        input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_be = be; bus_wdata = d;
    bus_addr = (ADDR_W'(ch) << 13) | ADDR_W'(off);
    @(negedge clk);
    bus_req = 0;
    chk("R1 ack", 32'(bus_ack), 32'd1);
    c_err = bus_err; c_rd = bus_rdata;
    c_ld_d = eng_load_d[ch % NUM_CH]; c_ld_c = eng_load_c[ch % NUM_CH];
    c_st = eng_start[ch % NUM_CH];
  endtask

  task automatic wr(input int ch, input logic [7:0] off, input logic [31:0] d);
    access(ch, off, 1'b1, d, 4'hF);
  endtask

  task automatic rd_chk(input int ch, input logic [7:0] off, input logic [31:0] exp,
                        input string req);
    access(ch, off, 1'b0, 32'd0, 4'hF);
    chk(req, c_rd, exp);
  endtask

  task automatic strobes(input string req, input logic d, input logic c, input logic s);
    chk(req, {29'd0, c_ld_d, c_ld_c, c_st}, {29'd0, d, c, s});
  endtask

  task automatic t_reset;
    rd_chk(0, 8'h88, 32'h101, "R3 status after reset");
    rd_chk(1, 8'h84, 32'h0, "R3 cfg after reset");
    chk("R3 irq after reset", 32'(irq), 32'd0);
  endtask

  task automatic t_cfg;
    wr(0, 8'h84, 32'h1);  rd_chk(0, 8'h88, 32'h101, "R4 enable keeps state");
    wr(0, 8'h84, 32'h3);  rd_chk(0, 8'h88, 32'h102, "R4 stop");
    wr(0, 8'h84, 32'h0);  rd_chk(0, 8'h88, 32'h101, "R4 back to reset state");
  endtask

  task automatic t_stream;
    wr(0, 8'h9C, 32'h40);  strobes("R5 bit6 load", 1, 0, 0);
    wr(0, 8'h9C, 32'h100); strobes("R5 bit8 load", 1, 0, 0);
    @(negedge clk); chk("R8 one-cycle strobe", 32'(eng_load_d[0]), 32'd0);
    wr(0, 8'h9C, 32'h20);  strobes("R6 bit5 alone", 0, 0, 0);
    wr(0, 8'h9C, 32'h200); strobes("R6 context load", 0, 1, 0);
    wr(0, 8'h9C, 32'h400); strobes("R5 high bits ignored", 0, 0, 0);
    rd_chk(0, 8'h88, 32'h101, "R5 no start yet");
    wr(0, 8'h9C, 32'h60);  strobes("R5 load and start", 1, 0, 1);
    rd_chk(0, 8'h88, 32'h104, "R5 running");
  endtask

  task automatic t_continue;
    wr(0, 8'h84, 32'h1);
    eng_desc_eol[0] = 1;
    wr(0, 8'h80, 32'h1); strobes("R7 continue", 1, 0, 1);
    eng_desc_eol[0] = 0;
    wr(0, 8'h80, 32'h1); strobes("R7 no eol no continue", 0, 0, 0);
    eng_desc_eol[0] = 1;
    wr(0, 8'h84, 32'h3);
    wr(0, 8'h80, 32'h1); strobes("R7 stopped no continue", 0, 0, 0);
    eng_desc_eol[0] = 0;
  endtask

  task automatic t_busy;
    wr(1, 8'h84, 32'h0);
    eng_busy[1] = 1;
    wr(1, 8'h9C, 32'h260); strobes("R8 busy blocks", 0, 0, 0);
    rd_chk(1, 8'h88, 32'h101, "R8 busy keeps state");
    eng_busy[1] = 0;
    eng_eol[1] = 1;
    rd_chk(1, 8'h88, 32'h121, "R3 eol flag bit5");
    eng_eol[1] = 0;
  endtask

  task automatic t_irq;
    @(negedge clk); eng_irq_set[2*IRQ_W +: IRQ_W] = 4'h5;
    @(negedge clk); eng_irq_set = '0;
    chk("R10 masked off irq low", 32'(irq[2]), 32'd0);
    rd_chk(2, 8'h94, 32'h5, "R9 raw set");
    wr(2, 8'h8C, 32'h4);
    chk("R10 irq after mask", 32'(irq[2]), 32'd1);
    rd_chk(2, 8'h98, 32'h4, "R10 masked value");
    wr(2, 8'h90, 32'h4);
    chk("R10 irq after ack", 32'(irq[2]), 32'd0);
    rd_chk(2, 8'h94, 32'h1, "R9 raw after ack");
    rd_chk(2, 8'h90, 32'h0, "R9 ack reads zero");
  endtask

  task automatic t_err_ptr;
    wr(1, 8'h58, 32'hA000_0040);
    wr(2, 8'h7C, 32'hB000_0080);
    wr(0, 8'h58, 32'h1234_5678);
    rd_chk(1, 8'h58, 32'hA000_0040, "R11 channel separation");
    chk("R11 desc_ptr port", desc_ptr[32 +: 32], 32'hA000_0040);
    chk("R11 ctx_ptr port", ctx_ptr[64 +: 32], 32'hB000_0080);
    access(1, 8'h58, 1'b1, 32'hDEAD_BEEF, 4'h3);
    chk("R2 sub-word err", 32'(c_err), 32'd1);
    rd_chk(1, 8'h58, 32'hA000_0040, "R2 sub-word no change");
    access(3, 8'h84, 1'b0, 32'd0, 4'hF);
    chk("R2 bad channel err", 32'(c_err), 32'd1);
    chk("R2 bad channel rdata", c_rd, 32'd0);
    wr(2, 8'h00, 32'h0000_1000);
    rd_chk(2, 8'h00, 32'h0000_1000, "R11 data pointer");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_cfg();
    t_stream();
    t_continue();
    t_busy();
    t_irq();
    t_err_ptr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule